// File: doc/BRIEF.md
# Toggle Register with Clear, Set and Load Controls

The block is a register of parameterized width built from toggle-type storage bits. It is clocked on the rising edge of `clk`. During normal operation each bit of `data` is a per-bit toggle enable. A 1 inverts the matching stored bit at the next edge, and a 0 leaves it unchanged. When a load is requested, the same bus supplies the value to load.

Three synchronous controls share one clock enable: clear, set and load. Three asynchronous controls override everything, including the clock: clear, set and load. Both set paths drive the configured set value when `HAS_SET_VALUE` is 1, and all ones when it is 0.

All control pins are plain levels with no handshake. An integrator that does not use a control ties it low. An integrator that does not use the enable ties it high.

Top module: `tflop_bank`

## Requirements
- R1: With `enable`=1 and every other control low, each rising edge makes `q` equal to the previous `q` XOR `data`.
- R2: With `enable`=0 and no asynchronous control active, a rising edge leaves `q` unchanged whatever `data`, `sclr`, `sset` and `sload` are.
- R3: With `enable`=1, `sclr`=1 makes `q` all zeros at the next edge, over `sset`, `sload` and toggling.
- R4: With `enable`=1 and `sclr`=0, `sset`=1 makes `q` equal to the set value at the next edge, over `sload` and toggling. The set value is `SET_VALUE` when `HAS_SET_VALUE`=1 and all ones otherwise.
- R5: With `enable`=1, `sclr`=0 and `sset`=0, `sload`=1 makes `q` equal to `data` at the next edge instead of toggling.
- R6: `aclr`=1 drives `q` to all zeros without waiting for a clock edge, over every other control and the clock.
- R7: `aset`=1 with `aclr`=0 drives `q` to the set value without a clock edge, and clock edges leave it there.
- R8: `aload`=1 with `aclr`=0 and `aset`=0 makes `q` follow `data` combinationally.
- R9: When all asynchronous controls go low, `q` keeps the value the override was forcing. That is the value at the most recent rising edge during the override, or at the override's onset if no edge occurred. Synchronous operation resumes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| enable | input | 1 | Clock enable for all synchronous actions |
| sclr | input | 1 | Synchronous clear |
| sset | input | 1 | Synchronous set |
| sload | input | 1 | Synchronous load of `data` |
| aclr | input | 1 | Asynchronous clear |
| aset | input | 1 | Asynchronous set |
| aload | input | 1 | Asynchronous load of `data` |
| data | input | WIDTH | Toggle enables, or load data |
| q | output | WIDTH | Register contents |

## Verification
Every synchronous result (R1 to R5, and R2's hold) is due one edge after the stimulus. The bench drives inputs on the falling edge and reads `q` on the next falling edge, half a cycle after the edge that produced the result.

Asynchronous results (R6 to R8) are due with no edge at all. The bench changes a control away from any clock edge and reads `q` one nanosecond later.

For R9, the bench releases the overrides on a falling edge and reads `q` both before and after the following rising edge.

// File: rtl/tflop_pkg.sv
package tflop_pkg;

  typedef enum logic [2:0] {
    SOP_HOLD   = 3'd0,
    SOP_TOGGLE = 3'd1,
    SOP_LOAD   = 3'd2,
    SOP_SET    = 3'd3,
    SOP_CLEAR  = 3'd4
  } sync_op_e;

  typedef enum logic [1:0] {
    AOP_NONE  = 2'd0,
    AOP_LOAD  = 2'd1,
    AOP_SET   = 2'd2,
    AOP_CLEAR = 2'd3
  } async_op_e;

  function automatic sync_op_e pick_sync(input logic en, input logic clr,
                                         input logic set, input logic ld);
    if (!en)     return SOP_HOLD;
    else if (clr) return SOP_CLEAR;
    else if (set) return SOP_SET;
    else if (ld)  return SOP_LOAD;
    else          return SOP_TOGGLE;
  endfunction

  function automatic async_op_e pick_async(input logic clr, input logic set,
                                           input logic ld);
    if (clr)      return AOP_CLEAR;
    else if (set) return AOP_SET;
    else if (ld)  return AOP_LOAD;
    else          return AOP_NONE;
  endfunction

endpackage

// File: rtl/tflop_setval.sv
module tflop_setval #(
  parameter int unsigned          WIDTH         = 8,
  parameter bit                   HAS_SET_VALUE = 1'b1,
  parameter logic [WIDTH-1:0]     SET_VALUE     = '1
) (
  output logic [WIDTH-1:0] set_word
);
  generate
    if (HAS_SET_VALUE) begin : g_cfg
      assign set_word = SET_VALUE;
    end else begin : g_ones
      assign set_word = {WIDTH{1'b1}};
    end
  endgenerate
endmodule

// File: rtl/tflop_async_sel.sv
module tflop_async_sel
  import tflop_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             aclr,
  input  logic             aset,
  input  logic             aload,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] set_word,
  output logic             force_on,
  output logic [WIDTH-1:0] force_val
);
  async_op_e op;

  always_comb begin
    op = pick_async(aclr, aset, aload);
    force_on = (op != AOP_NONE);
    unique case (op)
      AOP_CLEAR: force_val = '0;
      AOP_SET:   force_val = set_word;
      AOP_LOAD:  force_val = data;
      default:   force_val = '0;
    endcase
  end
endmodule

// File: rtl/tflop_sync_next.sv
module tflop_sync_next
  import tflop_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             enable,
  input  logic             sclr,
  input  logic             sset,
  input  logic             sload,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] set_word,
  output logic [WIDTH-1:0] nxt
);
  sync_op_e op;

  assign op = pick_sync(enable, sclr, sset, sload);

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
        unique case (op)
          SOP_CLEAR:  nxt[i] = 1'b0;
          SOP_SET:    nxt[i] = set_word[i];
          SOP_LOAD:   nxt[i] = data[i];
          SOP_TOGGLE: nxt[i] = data[i] ? ~cur[i] : cur[i];
          default:    nxt[i] = cur[i];
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/tflop_bank.sv
module tflop_bank #(
  parameter int unsigned      WIDTH         = 8,
  parameter bit               HAS_SET_VALUE = 1'b1,
  parameter logic [WIDTH-1:0] SET_VALUE     = 8'hA5
) (
  input  logic             clk,
  input  logic             enable,
  input  logic             sclr,
  input  logic             sset,
  input  logic             sload,
  input  logic             aclr,
  input  logic             aset,
  input  logic             aload,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] set_word;
  logic             force_on;
  logic [WIDTH-1:0] force_val;
  logic [WIDTH-1:0] nxt;
  logic [WIDTH-1:0] state_q;

  tflop_setval #(
    .WIDTH(WIDTH), .HAS_SET_VALUE(HAS_SET_VALUE), .SET_VALUE(SET_VALUE)
  ) setval_i (
    .set_word(set_word)
  );

  tflop_async_sel #(.WIDTH(WIDTH)) async_i (
    .aclr(aclr), .aset(aset), .aload(aload), .data(data),
    .set_word(set_word), .force_on(force_on), .force_val(force_val)
  );

  tflop_sync_next #(.WIDTH(WIDTH)) sync_i (
    .enable(enable), .sclr(sclr), .sset(sset), .sload(sload),
    .data(data), .cur(state_q), .set_word(set_word), .nxt(nxt)
  );

  always_ff @(posedge clk or posedge force_on) begin
    if (force_on) state_q <= force_val;
    else          state_q <= nxt;
  end

  assign q = force_on ? force_val : state_q;
endmodule

// File: rtl/tflop_bank_chk.sv
module tflop_bank_chk #(
  parameter int unsigned      WIDTH         = 8,
  parameter bit               HAS_SET_VALUE = 1'b1,
  parameter logic [WIDTH-1:0] SET_VALUE     = 8'hA5
) (
  input logic             clk,
  input logic             enable,
  input logic             sclr,
  input logic             sset,
  input logic             sload,
  input logic             aclr,
  input logic             aset,
  input logic             aload,
  input logic [WIDTH-1:0] data,
  input logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] SETW = HAS_SET_VALUE ? SET_VALUE : {WIDTH{1'b1}};

  logic armed = 1'b0;
  logic ovr;
  assign ovr = aclr | aset | aload;

  always_ff @(posedge clk) armed <= 1'b1;

  // R1
  toggle_chk: assert property (@(posedge clk) disable iff (!armed || ovr)
    (enable && !sclr && !sset && !sload && !ovr) |=> q == $past(q ^ data));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!armed || ovr)
    (!enable && !ovr) |=> $stable(q));

  // R3
  sclr_chk: assert property (@(posedge clk) disable iff (!armed || ovr)
    (enable && sclr && !ovr) |=> q == '0);

  // R4
  sset_chk: assert property (@(posedge clk) disable iff (!armed || ovr)
    (enable && !sclr && sset && !ovr) |=> q == SETW);

  // R5
  sload_chk: assert property (@(posedge clk) disable iff (!armed || ovr)
    (enable && !sclr && !sset && sload && !ovr) |=> q == $past(data));

  // R6
  aclr_chk: assert property (@(posedge clk) disable iff (!armed)
    aclr |-> q == '0);

  // R7
  aset_chk: assert property (@(posedge clk) disable iff (!armed)
    (aset && !aclr) |-> q == SETW);

  // R8
  aload_chk: assert property (@(posedge clk) disable iff (!armed)
    (aload && !aset && !aclr) |-> q == data);
endmodule

bind tflop_bank tflop_bank_chk #(
  .WIDTH(WIDTH), .HAS_SET_VALUE(HAS_SET_VALUE), .SET_VALUE(SET_VALUE)
) chk_i (
  .clk(clk), .enable(enable), .sclr(sclr), .sset(sset), .sload(sload),
  .aclr(aclr), .aset(aset), .aload(aload), .data(data), .q(q)
);

// File: tb/tflop_bank_tb_top.sv
`timescale 1ns/1ps
module tflop_bank_tb_top;
  localparam int W = 8;
  localparam logic [W-1:0] SV = 8'hA5;

  logic clk = 1'b0;
  logic enable = 1'b1, sclr = 1'b0, sset = 1'b0, sload = 1'b0;
  logic aclr = 1'b1, aset = 1'b0, aload = 1'b0;
  logic [W-1:0] data = '0;
  logic [W-1:0] q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tflop_bank #(.WIDTH(W), .HAS_SET_VALUE(1'b1), .SET_VALUE(SV)) dut_i (
    .clk(clk), .enable(enable), .sclr(sclr), .sset(sset), .sload(sload),
    .aclr(aclr), .aset(aset), .aload(aload), .data(data), .q(q)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (q !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, q, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    #5;
    check("R6", 8'h00);
    @(negedge clk);
    aclr = 1'b0;
    #1 check("R9", 8'h00);
  endtask

  task automatic t_toggle();
    data = 8'h0F; step(); check("R1", 8'h0F);
    data = 8'h3C; step(); check("R1", 8'h33);
    data = 8'h00; step(); check("R1", 8'h33);
  endtask

  task automatic t_enable_low();
    enable = 1'b0; data = 8'hFF; sclr = 1'b1; step(); check("R2", 8'h33);
    sclr = 1'b0; sset = 1'b1; sload = 1'b1; step(); check("R2", 8'h33);
    sset = 1'b0; sload = 1'b0; step(); check("R2", 8'h33);
    enable = 1'b1;
  endtask

  task automatic t_sync_prio();
    sclr = 1'b1; sset = 1'b1; sload = 1'b1; data = 8'hFF; step(); check("R3", 8'h00);
    sclr = 1'b0; data = 8'h3C; step(); check("R4", SV);
    sset = 1'b0; step(); check("R5", 8'h3C);
    data = 8'h81; step(); check("R5", 8'h81);
    sload = 1'b0; sset = 1'b1; data = 8'h00; step(); check("R4", SV);
    sset = 1'b0; sclr = 1'b1; step(); check("R3", 8'h00);
    sclr = 1'b0; data = 8'h00;
  endtask

  task automatic t_async_set();
    data = 8'hFF;
    #3 aset = 1'b1;
    #1 check("R7", SV);
    step(); check("R7", SV);
    #2 aclr = 1'b1;
    #1 check("R6", 8'h00);
    step(); check("R6", 8'h00);
    aclr = 1'b0; aset = 1'b0;
    #1 check("R9", 8'h00);
    data = 8'h0A; step(); check("R9", 8'h0A);
  endtask

  task automatic t_async_load();
    #3 data = 8'h5C; aload = 1'b1;
    #1 check("R8", 8'h5C);
    data = 8'hC3;
    #1 check("R8", 8'hC3);
    aset = 1'b1;
    #1 check("R7", SV);
    aset = 1'b0;
    #1 check("R8", 8'hC3);
    step(); check("R8", 8'hC3);
    aload = 1'b0;
    #1 check("R9", 8'hC3);
    data = 8'h01; step(); check("R9", 8'hC2);
  endtask

  task automatic t_mid_clear();
    #4 aclr = 1'b1;
    #1 check("R6", 8'h00);
    @(negedge clk);
    aclr = 1'b0;
    data = 8'h00; step(); check("R9", 8'h00);
  endtask

  initial begin
    t_reset();
    t_toggle();
    t_enable_low();
    t_sync_prio();
    t_async_set();
    t_async_load();
    t_mid_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule